// File: doc/BRIEF.md
# Streaming RGB to 4:2:2 Window Reducer

This block shrinks a raster video stream before later stages consume it. Each incoming pixel is 24-bit RGB, carried with a start-of-frame flag, an end-of-line flag and a valid/ready handshake. The block converts every pixel to YCbCr with fixed-point coefficients. It then halves the horizontal chroma rate so that each output pixel is 16 bits. Finally it keeps only a rectangular window of the frame. With the default parameters a 1920 x 1080 frame becomes a 1024 x 768 window.

The window origin comes from two offset inputs. The block samples them only on the start-of-frame pixel, so software may rewrite them at any time without tearing the frame in flight. The origin is forced to an even column, which keeps the Cb/Cr phase intact, and it is clamped so that the window always lies inside the frame. The output stream has its own frame and line flags. Its ready input stalls the whole pipeline as one unit, so no pixel is lost or sent twice.

Top module: `vpr_reduce_pipe`

## Requirements
- R1: After reset, out_valid_o is low and in_ready_o is high.
- R2: The input pixel carries R in bits 23:16, G in 15:8 and B in 7:0. Luma is Y = (77R + 150G + 29B + 128) >> 8.
- R3: Chroma is Cb = (-43R - 85G + 128B + 32896) >> 8 and Cr = (128R - 107G - 21B + 32896) >> 8, each clamped to 0..255.
- R4: Columns are paired as (even, odd) from column 0. The output for the even column is {avg(Cb0,Cb1), Y0} and the output for the odd column is {avg(Cr0,Cr1), Y1}. Chroma sits in bits 15:8, luma in bits 7:0, and avg(a,b) = (a+b+1)>>1.
- R5: The output holds exactly the pixels with xo <= x < xo+CROP_W and yo <= y < yo+CROP_H, in raster order. Column x counts from the start-of-frame or end-of-line pixel.
- R6: x_off_i and y_off_i are sampled only on the accepted start-of-frame pixel. Changes during the frame have no effect on that frame.
- R7: The effective X offset is x_off_i with bit 0 cleared, limited to IMG_W-CROP_W. The effective Y offset is y_off_i limited to IMG_H-CROP_H.
- R8: out_sof_o is high only on the first window pixel of a frame. out_eol_o is high only on the last pixel of each window line.
- R9: While out_valid_o is high and out_ready_i is low, the output pixel and its flags stay unchanged. Every window pixel leaves exactly once.
- R10: With out_ready_i held high, in_ready_o stays high, so the block takes one pixel per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted when high with valid |
| in_rgb_i | input | 24 | RGB pixel, R in 23:16, G in 15:8, B in 7:0 |
| in_sof_i | input | 1 | First pixel of frame |
| in_eol_i | input | 1 | Last pixel of input line |
| x_off_i | input | XW (11) | Window column offset, sampled at start of frame |
| y_off_i | input | YW (11) | Window row offset, sampled at start of frame |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream ready |
| out_pix_o | output | 16 | 4:2:2 pixel, chroma 15:8, luma 7:0 |
| out_sof_o | output | 1 | First pixel of window |
| out_eol_o | output | 1 | Last pixel of window line |

## Verification
The riskiest overlap is an output stall in the cycle that the chroma stage has both a finished odd sample parked for emission and a new even pixel arriving. Here the global stall must freeze the parked sample and the incoming pixel together. The bench provokes this with a pseudo-random drop of out_ready_i during a full frame. It judges the result by the order of the scoreboard and by a hold check on every stalled cycle. A second overlap, an offset rewrite landing mid-frame, is driven partway through a frame and is judged by comparing against the window that was sampled at start of frame.

// File: rtl/vpr_pkg.sv
package vpr_pkg;
  localparam int CW = 8;

  // fixed-point colour coefficients, 8 fractional bits
  localparam int K_YR = 77, K_YG = 150, K_YB = 29;
  localparam int K_BR = -43, K_BG = -85, K_BB = 128;
  localparam int K_RR = 128, K_RG = -107, K_RB = -21;
  localparam int K_RND = 128;
  localparam int K_OFS = 32768 + 128;

  typedef struct packed {
    logic [CW-1:0] y;
    logic [CW-1:0] cb;
    logic [CW-1:0] cr;
  } ycc_t;

  typedef struct packed {
    logic win;
    logic first;
    logic last;
    logic odd;
  } vpr_tag_t;

  function automatic logic [CW-1:0] sat8(input int v);
    if (v < 0) return '0;
    if (v > 255) return 8'hff;
    return v[CW-1:0];
  endfunction
endpackage

// File: rtl/vpr_win_track.sv
module vpr_win_track
  import vpr_pkg::*;
#(
  parameter int IMG_W  = 1920,
  parameter int IMG_H  = 1080,
  parameter int CROP_W = 1024,
  parameter int CROP_H = 768,
  parameter int XW     = $clog2(IMG_W),
  parameter int YW     = $clog2(IMG_H)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          sof_i,
  input  logic          eol_i,
  input  logic [XW-1:0] x_off_i,
  input  logic [YW-1:0] y_off_i,
  output vpr_tag_t      tag_o
);
  localparam int XW1 = XW + 1;
  localparam int YW1 = YW + 1;
  localparam logic [XW1-1:0] XMAX = XW1'(IMG_W - CROP_W);
  localparam logic [YW1-1:0] YMAX = YW1'(IMG_H - CROP_H);

  logic [XW1-1:0] x_q, xo_q, x_cur, xo_raw, xo_new, xo_use;
  logic [YW1-1:0] y_q, yo_q, y_cur, yo_raw, yo_new, yo_use;

  always_comb begin
    xo_raw    = {1'b0, x_off_i};
    xo_raw[0] = 1'b0;  // keep chroma phase
    xo_new    = (xo_raw > XMAX) ? XMAX : xo_raw;
    yo_raw    = {1'b0, y_off_i};
    yo_new    = (yo_raw > YMAX) ? YMAX : yo_raw;
    xo_use    = sof_i ? xo_new : xo_q;
    yo_use    = sof_i ? yo_new : yo_q;
    x_cur     = sof_i ? '0 : x_q;
    y_cur     = sof_i ? '0 : y_q;
  end

  always_comb begin
    tag_o.win   = (x_cur >= xo_use) && (x_cur < xo_use + XW1'(CROP_W)) &&
                  (y_cur >= yo_use) && (y_cur < yo_use + YW1'(CROP_H));
    tag_o.first = (x_cur == xo_use) && (y_cur == yo_use);
    tag_o.last  = (x_cur == xo_use + XW1'(CROP_W - 1));
    tag_o.odd   = x_cur[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q  <= '0;
      y_q  <= '0;
      xo_q <= '0;
      yo_q <= '0;
    end else if (fire_i) begin
      x_q <= eol_i ? '0 : x_cur + 1'b1;
      y_q <= eol_i ? y_cur + 1'b1 : y_cur;
      if (sof_i) begin
        xo_q <= xo_new;
        yo_q <= yo_new;
      end
    end
  end

  p_clip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xo_q <= XMAX) && !xo_q[0] && (yo_q <= YMAX));
endmodule

// File: rtl/vpr_csc.sv
module vpr_csc
  import vpr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      adv_i,
  input  logic      vld_i,
  input  logic [23:0] rgb_i,
  input  vpr_tag_t  tag_i,
  output logic      vld_o,
  output ycc_t      ycc_o,
  output vpr_tag_t  tag_o
);
  int   r, g, b, ay, acb, acr;
  ycc_t ycc_d;

  always_comb begin
    r   = int'(rgb_i[23:16]);
    g   = int'(rgb_i[15:8]);
    b   = int'(rgb_i[7:0]);
    ay  = K_YR * r + K_YG * g + K_YB * b + K_RND;
    acb = K_BR * r + K_BG * g + K_BB * b + K_OFS;
    acr = K_RR * r + K_RG * g + K_RB * b + K_OFS;
    ycc_d.y  = sat8(ay >>> 8);
    ycc_d.cb = sat8(acb >>> 8);
    ycc_d.cr = sat8(acr >>> 8);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      ycc_o <= '0;
      tag_o <= '0;
    end else if (adv_i) begin
      vld_o <= vld_i;
      if (vld_i) begin
        ycc_o <= ycc_d;
        tag_o <= tag_i;
      end
    end
  end
endmodule

// File: rtl/vpr_chroma422.sv
module vpr_chroma422
  import vpr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        adv_i,
  input  logic        vld_i,
  input  ycc_t        ycc_i,
  input  vpr_tag_t    tag_i,
  output logic        vld_o,
  output logic [15:0] pix_o,
  output vpr_tag_t    tag_o
);
  ycc_t        hold_q;
  vpr_tag_t    hold_tag_q;
  logic        pend_v_q;
  logic [15:0] pend_pix_q;
  vpr_tag_t    pend_tag_q;
  logic [8:0]  sum_cb, sum_cr;

  assign sum_cb = {1'b0, hold_q.cb} + {1'b0, ycc_i.cb} + 9'd1;
  assign sum_cr = {1'b0, hold_q.cr} + {1'b0, ycc_i.cr} + 9'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_tag_q <= '0;
      pend_v_q   <= 1'b0;
      pend_pix_q <= '0;
      pend_tag_q <= '0;
      vld_o      <= 1'b0;
      pix_o      <= '0;
      tag_o      <= '0;
    end else if (adv_i) begin
      if (vld_i && !tag_i.odd) begin
        hold_q     <= ycc_i;
        hold_tag_q <= tag_i;
      end
      if (vld_i && tag_i.odd) begin
        // emit even sample now, park odd sample for next slot
        vld_o      <= 1'b1;
        pix_o      <= {sum_cb[8:1], hold_q.y};
        tag_o      <= hold_tag_q;
        pend_v_q   <= 1'b1;
        pend_pix_q <= {sum_cr[8:1], ycc_i.y};
        pend_tag_q <= tag_i;
      end else if (pend_v_q) begin
        vld_o    <= 1'b1;
        pix_o    <= pend_pix_q;
        tag_o    <= pend_tag_q;
        pend_v_q <= 1'b0;
      end else begin
        vld_o <= 1'b0;
      end
    end
  end

  // an odd column always follows an even one, so the parked slot is free
  p_pair_slot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && vld_i && tag_i.odd) |-> !pend_v_q);
endmodule

// File: rtl/vpr_crop.sv
module vpr_crop
  import vpr_pkg::*;
#(
  parameter int CROP_W = 1024
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        adv_i,
  input  logic        rdy_i,
  input  logic        vld_i,
  input  logic [15:0] pix_i,
  input  vpr_tag_t    tag_i,
  output logic        vld_o,
  output logic [15:0] pix_o,
  output logic        sof_o,
  output logic        eol_o
);
  localparam int COLW = $clog2(CROP_W) + 1;

  logic [COLW-1:0] col_q;
  logic            fire;

  assign fire = vld_o && rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      pix_o <= '0;
      sof_o <= 1'b0;
      eol_o <= 1'b0;
    end else if (adv_i) begin
      vld_o <= vld_i && tag_i.win;
      if (vld_i && tag_i.win) begin
        pix_o <= pix_i;
        sof_o <= tag_i.first;
        eol_o <= tag_i.last;
      end
    end
  end

  // output column count for marker checks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   col_q <= '0;
    else if (fire) col_q <= eol_o ? '0 : col_q + 1'b1;
  end

  p_eol_col_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && eol_o) |-> (col_q == COLW'(CROP_W - 1)));
  p_sof_col_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && sof_o) |-> (col_q == '0));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !rdy_i) |=> (vld_o && $stable(pix_o) && $stable(sof_o) && $stable(eol_o)));
endmodule

// File: rtl/vpr_reduce_pipe.sv
module vpr_reduce_pipe
  import vpr_pkg::*;
#(
  parameter int IMG_W  = 1920,
  parameter int IMG_H  = 1080,
  parameter int CROP_W = 1024,
  parameter int CROP_H = 768,
  parameter int XW     = $clog2(IMG_W),
  parameter int YW     = $clog2(IMG_H)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [23:0]   in_rgb_i,
  input  logic          in_sof_i,
  input  logic          in_eol_i,
  input  logic [XW-1:0] x_off_i,
  input  logic [YW-1:0] y_off_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [15:0]   out_pix_o,
  output logic          out_sof_o,
  output logic          out_eol_o
);
  logic        adv, fire_in;
  vpr_tag_t    tag_in, tag_c, tag_s;
  logic        vld_c, vld_s;
  ycc_t        ycc_c;
  logic [15:0] pix_s;

  // one stall term freezes every stage together
  assign adv        = !out_valid_o || out_ready_i;
  assign in_ready_o = adv;
  assign fire_in    = in_valid_i && adv;

  vpr_win_track #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .CROP_W(CROP_W), .CROP_H(CROP_H),
    .XW(XW), .YW(YW)
  ) u_track (
    .clk_i, .rst_ni,
    .fire_i (fire_in),
    .sof_i  (in_sof_i),
    .eol_i  (in_eol_i),
    .x_off_i,
    .y_off_i,
    .tag_o  (tag_in)
  );

  vpr_csc u_csc (
    .clk_i, .rst_ni,
    .adv_i (adv),
    .vld_i (in_valid_i),
    .rgb_i (in_rgb_i),
    .tag_i (tag_in),
    .vld_o (vld_c),
    .ycc_o (ycc_c),
    .tag_o (tag_c)
  );

  vpr_chroma422 u_c422 (
    .clk_i, .rst_ni,
    .adv_i (adv),
    .vld_i (vld_c),
    .ycc_i (ycc_c),
    .tag_i (tag_c),
    .vld_o (vld_s),
    .pix_o (pix_s),
    .tag_o (tag_s)
  );

  vpr_crop #(.CROP_W(CROP_W)) u_crop (
    .clk_i, .rst_ni,
    .adv_i (adv),
    .rdy_i (out_ready_i),
    .vld_i (vld_s),
    .pix_i (pix_s),
    .tag_i (tag_s),
    .vld_o (out_valid_o),
    .pix_o (out_pix_o),
    .sof_o (out_sof_o),
    .eol_o (out_eol_o)
  );
endmodule

// File: tb/vpr_reduce_pipe_tb.sv
module vpr_reduce_pipe_tb;
  localparam int W = 16, H = 8, CWD = 8, CHT = 4;
  localparam int XW = $clog2(W), YW = $clog2(H);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0, out_ready = 1'b1;
  logic [23:0] in_rgb = '0;
  logic [XW-1:0] x_off = '0;
  logic [YW-1:0] y_off = '0;
  logic in_ready, out_valid, out_sof, out_eol;
  logic [15:0] out_pix;

  int n_tests = 0, n_fail = 0, stalls = 0;
  bit rand_ready = 0, done = 0;
  logic [15:0] exp_pix[$];
  logic        exp_sof[$], exp_eol[$];
  string       exp_rq[$];
  bit          prev_stall = 0;
  logic [17:0] prev_out = '0;

  always #2.5 clk = ~clk;

  vpr_reduce_pipe #(.IMG_W(W), .IMG_H(H), .CROP_W(CWD), .CROP_H(CHT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_rgb_i(in_rgb),
    .in_sof_i(in_sof), .in_eol_i(in_eol), .x_off_i(x_off), .y_off_i(y_off),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_pix_o(out_pix),
    .out_sof_o(out_sof), .out_eol_o(out_eol)
  );

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int clamp(int v);
    return v < 0 ? 0 : (v > 255 ? 255 : v);
  endfunction

  function automatic logic [23:0] gen_rgb(int f, int x, int y);
    int r, g, b;
    if (f == 1) begin
      case ((x + y) % 6)
        0: return 24'h000000;
        1: return 24'hffffff;
        2: return 24'hff0000;
        3: return 24'h0000ff;
        4: return 24'h00ff00;
        default: return 24'hff00ff;
      endcase
    end
    if (f == 2) return (x % 2 == 0) ? {8'(200 + y), 8'd3, 8'd10} : {8'd5, 8'(40 + x), 8'(251 - y)};
    r = (x * 37 + y * 11 + f * 53) & 255;
    g = ((x * 13) ^ (y * 71 + f * 7)) & 255;
    b = (x * x + y * 29 + f * 91) & 255;
    return {r[7:0], g[7:0], b[7:0]};
  endfunction

  // model of R2, R3: returns {Y, Cb, Cr}
  function automatic logic [23:0] to_ycc(logic [23:0] p);
    int r = p[23:16], g = p[15:8], b = p[7:0];
    int yy = clamp((77 * r + 150 * g + 29 * b + 128) >>> 8);
    int cb = clamp((-43 * r - 85 * g + 128 * b + 32896) >>> 8);
    int cr = clamp((128 * r - 107 * g - 21 * b + 32896) >>> 8);
    return {yy[7:0], cb[7:0], cr[7:0]};
  endfunction

  task automatic send_frame(int f, int xo, int yo, bit chg, string rq);
    int ex, ey;
    ex = xo & ~1;
    if (ex > W - CWD) ex = W - CWD;   // R7 clip
    ey = (yo > H - CHT) ? H - CHT : yo;
    for (int y = ey; y < ey + CHT; y++)
      for (int x = ex; x < ex + CWD; x += 2) begin
        logic [23:0] a, b;
        int c0, c1;
        a  = to_ycc(gen_rgb(f, x, y));
        b  = to_ycc(gen_rgb(f, x + 1, y));
        c0 = (int'(a[15:8]) + int'(b[15:8]) + 1) >> 1;
        c1 = (int'(a[7:0]) + int'(b[7:0]) + 1) >> 1;
        exp_pix.push_back({c0[7:0], a[23:16]});
        exp_sof.push_back(x == ex && y == ey);
        exp_eol.push_back(1'b0);
        exp_rq.push_back(rq);
        exp_pix.push_back({c1[7:0], b[23:16]});
        exp_sof.push_back(1'b0);
        exp_eol.push_back(x + 1 == ex + CWD - 1);
        exp_rq.push_back(rq);
      end
    x_off = XW'(xo);
    y_off = YW'(yo);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        if (chg && y == 1 && x == 4) begin
          x_off = '0;   // R6 mid-frame rewrite
          y_off = '0;
        end
        in_valid = 1'b1;
        in_rgb   = gen_rgb(f, x, y);
        in_sof   = (x == 0 && y == 0);
        in_eol   = (x == W - 1);
        forever begin
          @(negedge clk);
          if (in_ready) break;
          stalls++;
        end
        @(posedge clk);
        #1;
      end
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eol   = 1'b0;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_stall)
        chk(out_valid && {out_pix, out_sof, out_eol} == prev_out, "R9", "held output",
            int'({out_valid, out_pix, out_sof, out_eol}), int'({1'b1, prev_out}));
      if (out_valid && out_ready) begin
        if (exp_pix.size() == 0) begin
          chk(1'b0, "R9", "unexpected pixel", int'(out_pix), 0);
        end else begin
          logic [15:0] ep;
          logic        es, ee;
          string       er;
          ep = exp_pix.pop_front();
          es = exp_sof.pop_front();
          ee = exp_eol.pop_front();
          er = exp_rq.pop_front();
          chk(out_pix == ep, er, "pixel", int'(out_pix), int'(ep));
          chk({out_sof, out_eol} == {es, ee}, "R8", "markers",
              int'({out_sof, out_eol}), int'({es, ee}));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_out   = {out_pix, out_sof, out_eol};
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready <= rand_ready ? ($urandom % 3 != 0) : 1'b1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired act=%0d exp=0 pending", exp_pix.size());
    done = 1;
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);
    @(posedge clk);
    #1;
    stalls = 0;
    send_frame(0, 0, 0, 1'b0, "R2");
    send_frame(3, 2, 1, 1'b0, "R5");
    send_frame(1, 4, 2, 1'b0, "R3");
    send_frame(2, 2, 0, 1'b0, "R4");
    send_frame(4, 15, 7, 1'b0, "R7");
    send_frame(5, 3, 1, 1'b0, "R7");
    send_frame(6, 4, 2, 1'b1, "R6");
    chk(stalls == 0, "R10", "input stalls with ready high", stalls, 0);
    rand_ready = 1;
    send_frame(7, 6, 3, 1'b0, "R9");
    send_frame(8, 8, 4, 1'b0, "R9");
    rand_ready = 0;
    for (int i = 0; i < 200 && exp_pix.size() != 0; i++) @(posedge clk);
    repeat (4) @(posedge clk);
    chk(exp_pix.size() == 0, "R9", "pixels left over", exp_pix.size(), 0);
    done = 1;
    summary();
  end
endmodule